// File: doc/BRIEF.md
# Old/New Field Read Classifier

This block sits beside a two-port field memory, a write port and a read port that share one reference clock. It watches the write-side and read-side address reset strobes and measures how many clock cycles separate the latest write reset from the next read reset. From that distance it tells the system which field the read port is about to stream out. A short lag means the previous field, because the write side has not yet overtaken it. A long lag, still within the memory depth, means the field now being written. Any distance in between, or past the depth, gives a mixture that cannot be predicted, and a hazard flag is raised.

The same block also brings the memory up after power-on. It waits a programmable number of cycles for the supply to settle. It then issues a run of dummy clock cycles on the write port and, at the same time, on the read port. After its last dummy cycle, each port receives one reset strobe. A ready flag stays low until both ports have finished. After a supply glitch, a recovery request replays the start-up on each port as reset, dummy cycles, then reset again.

All band edges, the depth, the dummy counts and the settle wait are parameters, so a scaled-down configuration can be exercised quickly.

Top module: `fld_read_classifier`

## Requirements
- R1: While rst_ni is low and before any read reset, cls_o is 2'b00 (none), hazard_o is 0, and ready_o, dummy_wr_o, dummy_rd_o, init_wr_rst_o and init_rd_rst_o are all 0.
- R2: The lag is the number of clock cycles from the cycle in which wr_rst_i is sampled high to the cycle in which rd_rst_i is sampled high, or 0 if both are high in the same cycle. cls_o takes the new code in the cycle after rd_rst_i is sampled and holds it until the next read reset; a write reset alone does not change it.
- R3: A lag of at most OLD_MAX cycles gives cls_o = 2'b01 (old field) and hazard_o = 0.
- R4: A lag from NEW_MIN to DEPTH cycles inclusive gives cls_o = 2'b10 (new field) and hazard_o = 0.
- R5: A lag from OLD_MAX+1 to NEW_MIN-1 gives cls_o = 2'b11 (undetermined). hazard_o is 1 exactly when cls_o is 2'b11.
- R6: A lag above DEPTH gives cls_o = 2'b11. The lag counter saturates at DEPTH+1, and starts saturated after reset, so a read reset with no write reset since reset gives 2'b11.
- R7: With the reset released, the first dummy cycle on each port occurs PWR_WAIT cycles after release: cycles 0 to PWR_WAIT-1 are idle and cycle PWR_WAIT carries a dummy.
- R8: dummy_wr_o is high for exactly N_WR consecutive cycles and dummy_rd_o for exactly N_RD, and both runs start in the same cycle.
- R9: Each port's init reset output pulses for exactly one cycle, immediately after that port's last dummy cycle.
- R10: ready_o rises in the cycle after the later of the two port resets, stays low before that, and stays high afterwards.
- R11: When recover_i is sampled high while ready_o is high, ready_o drops in the next cycle. Each port then gives one reset cycle, N dummy cycles and one reset cycle, and ready_o returns the cycle after the later port finishes.
- R12: recover_i sampled while ready_o is low has no effect on the start-up sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_rst_i | input | 1 | Observed write address reset strobe |
| rd_rst_i | input | 1 | Observed read address reset strobe |
| recover_i | input | 1 | Request to replay start-up after a supply glitch |
| cls_o | output | 2 | Field code: 00 none, 01 old, 10 new, 11 undetermined |
| hazard_o | output | 1 | High when the current code is undetermined |
| ready_o | output | 1 | Start-up or recovery sequence complete |
| dummy_wr_o | output | 1 | Dummy clock cycle request for the write port |
| dummy_rd_o | output | 1 | Dummy clock cycle request for the read port |
| init_wr_rst_o | output | 1 | Init reset strobe for the write port |
| init_rd_rst_o | output | 1 | Init reset strobe for the read port |

## Verification
The bench sweeps every lag from 0 to DEPTH+10 in a reduced configuration and checks both band edges on each side. An off-by-one in the lag count would misplace 20/21 or 149/150, and a missing upper bound would call lags beyond the depth new data. It also reads before any write reset, where a counter that reset to zero would wrongly report old data. It checks that a lone write reset leaves the code untouched. It times the start-up and recovery sequences cycle by cycle with different dummy counts per port, which catches a ready flag raised by the faster port alone, a reset pulse that comes one cycle late, or a recovery request accepted during the initial start-up.

// File: rtl/fld_cls_pkg.sv
package fld_cls_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'b00,
    CLS_OLD   = 2'b01,
    CLS_NEW   = 2'b10,
    CLS_UNDET = 2'b11
  } fld_cls_e;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PRE,
    SEQ_DUMMY,
    SEQ_POST,
    SEQ_DONE
  } seq_st_e;
endpackage

// File: rtl/fld_lag_cnt.sv
module fld_lag_cnt #(
  parameter int unsigned DEPTH = 262214,
  localparam int unsigned CW = $clog2(DEPTH + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_rst_i,
  output logic [CW-1:0] lag_o
);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH + 1);

  logic [CW-1:0] cnt_q;

  // Loads 1 so that a read reset k cycles later sees k.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CMAX;
    else if (wr_rst_i)       cnt_q <= CW'(1);
    else if (cnt_q != CMAX)  cnt_q <= cnt_q + CW'(1);
  end

  assign lag_o = wr_rst_i ? '0 : cnt_q;

  a_r6_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CMAX && !wr_rst_i) |=> (cnt_q == CMAX));

  a_r6_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX);
endmodule

// File: rtl/fld_band_cls.sv
module fld_band_cls
  import fld_cls_pkg::*;
#(
  parameter int unsigned DEPTH   = 262214,
  parameter int unsigned OLD_MAX = 20,
  parameter int unsigned NEW_MIN = 150,
  localparam int unsigned CW = $clog2(DEPTH + 2)
) (
  input  logic [CW-1:0] lag_i,
  output fld_cls_e      cls_o
);
  always_comb begin
    if (lag_i <= CW'(OLD_MAX))
      cls_o = CLS_OLD;
    else if (lag_i >= CW'(NEW_MIN) && lag_i <= CW'(DEPTH))
      cls_o = CLS_NEW;
    else
      cls_o = CLS_UNDET;
  end
endmodule

// File: rtl/fld_port_seq.sv
module fld_port_seq
  import fld_cls_pkg::*;
#(
  parameter int unsigned N_DUMMY = 80,
  localparam int unsigned DW = $clog2(N_DUMMY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic rec_i,
  output logic dummy_o,
  output logic rst_o,
  output logic done_o
);
  seq_st_e       st_q, st_d;
  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SEQ_IDLE: if (go_i) begin st_d = SEQ_DUMMY; cnt_d = '0; end
      SEQ_PRE:  begin st_d = SEQ_DUMMY; cnt_d = '0; end
      SEQ_DUMMY: begin
        cnt_d = cnt_q + DW'(1);
        if (cnt_q == DW'(N_DUMMY - 1)) st_d = SEQ_POST;
      end
      SEQ_POST: st_d = SEQ_DONE;
      SEQ_DONE: if (rec_i) st_d = SEQ_PRE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign dummy_o = (st_q == SEQ_DUMMY);
  assign rst_o   = (st_q == SEQ_PRE) || (st_q == SEQ_POST);
  assign done_o  = (st_q == SEQ_DONE);

  a_r9_reset_after_dummy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dummy_o) |-> rst_o);

  a_r10_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !rec_i) |=> done_o);
endmodule

// File: rtl/fld_read_classifier.sv
module fld_read_classifier
  import fld_cls_pkg::*;
#(
  parameter int unsigned DEPTH    = 262214,
  parameter int unsigned OLD_MAX  = 20,
  parameter int unsigned NEW_MIN  = 150,
  parameter int unsigned N_WR     = 80,
  parameter int unsigned N_RD     = 80,
  parameter int unsigned PWR_WAIT = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_rst_i,
  input  logic       rd_rst_i,
  input  logic       recover_i,
  output logic [1:0] cls_o,
  output logic       hazard_o,
  output logic       ready_o,
  output logic       dummy_wr_o,
  output logic       dummy_rd_o,
  output logic       init_wr_rst_o,
  output logic       init_rd_rst_o
);
  localparam int unsigned CW = $clog2(DEPTH + 2);
  localparam int unsigned WW = $clog2(PWR_WAIT + 1);

  // Lag measurement and band decode
  logic [CW-1:0] lag;
  fld_cls_e      band, cls_q;

  fld_lag_cnt #(.DEPTH(DEPTH)) u_lag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_rst_i(wr_rst_i),
    .lag_o   (lag)
  );

  fld_band_cls #(.DEPTH(DEPTH), .OLD_MAX(OLD_MAX), .NEW_MIN(NEW_MIN)) u_band (
    .lag_i(lag),
    .cls_o(band)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cls_q <= CLS_NONE;
    else if (rd_rst_i) cls_q <= band;
  end

  assign cls_o    = cls_q;
  assign hazard_o = (cls_q == CLS_UNDET);

  // Supply settle wait
  logic [WW-1:0] wait_q;
  logic          go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    wait_q <= '0;
    else if (wait_q != WW'(PWR_WAIT)) wait_q <= wait_q + WW'(1);
  end

  assign go = (wait_q == WW'(PWR_WAIT - 1));

  // Per-port start-up sequencers: index 0 write, 1 read
  logic [1:0] dummy_v, rst_v, done_v;
  logic       rec_go;

  assign rec_go = recover_i & ready_o;

  for (genvar g = 0; g < 2; g++) begin : g_port
    localparam int unsigned NG = (g == 0) ? N_WR : N_RD;
    fld_port_seq #(.N_DUMMY(NG)) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .go_i   (go),
      .rec_i  (rec_go),
      .dummy_o(dummy_v[g]),
      .rst_o  (rst_v[g]),
      .done_o (done_v[g])
    );
  end

  assign ready_o       = &done_v;
  assign dummy_wr_o    = dummy_v[0];
  assign dummy_rd_o    = dummy_v[1];
  assign init_wr_rst_o = rst_v[0];
  assign init_rd_rst_o = rst_v[1];

  a_r2_hold_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_rst_i |=> $stable(cls_o));

  a_r8_not_ready_in_dummy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dummy_wr_o || dummy_rd_o) |-> !ready_o);

  a_r11_recover_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && recover_i) |=> !ready_o);

  a_r12_no_early_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !(init_wr_rst_o || init_rd_rst_o || dummy_wr_o || dummy_rd_o)
      && wait_q != WW'(PWR_WAIT)) |=> !(init_wr_rst_o || init_rd_rst_o));
endmodule

// File: tb/sim_fld_read_classifier.sv
module sim_fld_read_classifier;
  localparam int W = 12, NW = 8, NR = 5, DEPTH = 300, OLDM = 20, NEWM = 150;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_rst_i = 0, rd_rst_i = 0, recover_i = 0;
  logic [1:0] cls_o;
  logic hazard_o, ready_o, dummy_wr_o, dummy_rd_o, init_wr_rst_o, init_rd_rst_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fld_read_classifier #(
    .DEPTH(DEPTH), .OLD_MAX(OLDM), .NEW_MIN(NEWM),
    .N_WR(NW), .N_RD(NR), .PWR_WAIT(W)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_rst_i(wr_rst_i), .rd_rst_i(rd_rst_i),
    .recover_i(recover_i), .cls_o(cls_o), .hazard_o(hazard_o), .ready_o(ready_o),
    .dummy_wr_o(dummy_wr_o), .dummy_rd_o(dummy_rd_o),
    .init_wr_rst_o(init_wr_rst_o), .init_rd_rst_o(init_rd_rst_o)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int exp_cls(input int d);
    if (d <= OLDM) return 1;
    if (d >= NEWM && d <= DEPTH) return 2;
    return 3;
  endfunction

  // Write reset, then read reset d cycles later; sample the cycle after.
  task automatic lag_case(input int d);
    string rq;
    int e;
    e = exp_cls(d);
    rq = (e == 1) ? "R3 old" : (e == 2) ? "R4 new" : (d > DEPTH) ? "R6 beyond depth" : "R5 middle";
    wr_rst_i = 1; rd_rst_i = (d == 0);
    @(negedge clk); wr_rst_i = 0; rd_rst_i = 0;
    for (int i = 1; i < d; i++) @(negedge clk);
    if (d > 0) begin rd_rst_i = 1; @(negedge clk); rd_rst_i = 0; end
    chk($sformatf("%s R2 lag %0d cls", rq, d), cls_o, e);
    chk($sformatf("R5 lag %0d hazard", d), hazard_o, (e == 3) ? 1 : 0);
    repeat (3) @(negedge clk);
  endtask

  // Time the start-up (rec=0, recover pulsed at k=3) or recovery (rec=1).
  task automatic watch(input bit rec);
    int n[2], first_d[2], cnt_d[2], first_r[2], last_r[2], cnt_r[2];
    int first_rdy, rdy_k1, horizon, mx;
    bit dv[2], rv[2];
    n[0] = NW; n[1] = NR;
    mx = (NW > NR) ? NW : NR;
    horizon = (rec ? 0 : W) + mx + 8;
    for (int p = 0; p < 2; p++) begin
      first_d[p] = -1; cnt_d[p] = 0; first_r[p] = -1; last_r[p] = -1; cnt_r[p] = 0;
    end
    first_rdy = -1; rdy_k1 = -1;
    for (int k = 0; k < horizon; k++) begin
      recover_i = rec ? (k == 0) : (k == 3);
      dv[0] = dummy_wr_o; dv[1] = dummy_rd_o;
      rv[0] = init_wr_rst_o; rv[1] = init_rd_rst_o;
      for (int p = 0; p < 2; p++) begin
        if (dv[p]) begin if (first_d[p] < 0) first_d[p] = k; cnt_d[p]++; end
        if (rv[p]) begin if (first_r[p] < 0) first_r[p] = k; last_r[p] = k; cnt_r[p]++; end
      end
      if (k == 1) rdy_k1 = ready_o;
      if (k >= 1 && ready_o && first_rdy < 0) first_rdy = k;
      @(negedge clk);
    end
    recover_i = 0;
    for (int p = 0; p < 2; p++) begin
      if (rec) begin
        chk($sformatf("R11 port%0d first reset", p), first_r[p], 1);
        chk($sformatf("R11 port%0d first dummy", p), first_d[p], 2);
        chk($sformatf("R11 R9 port%0d last reset", p), last_r[p], n[p] + 2);
        chk($sformatf("R11 port%0d reset count", p), cnt_r[p], 2);
      end else begin
        chk($sformatf("R7 R12 port%0d first dummy", p), first_d[p], W);
        chk($sformatf("R9 port%0d reset index", p), last_r[p], W + n[p]);
        chk($sformatf("R9 R12 port%0d reset count", p), cnt_r[p], 1);
      end
      chk($sformatf("R8 port%0d dummy count", p), cnt_d[p], n[p]);
    end
    if (rec) begin
      chk("R11 ready dropped", rdy_k1, 0);
      chk("R11 ready return", first_rdy, mx + 3);
    end else
      chk("R10 R12 ready rise", first_rdy, W + mx + 1);
    chk("R10 ready stays high", ready_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cls", cls_o, 0);
    chk("R1 hazard", hazard_o, 0);
    chk("R1 ready", ready_o, 0);
    chk("R1 seq outputs", {dummy_wr_o, dummy_rd_o, init_wr_rst_o, init_rd_rst_o}, 0);
    rst_ni = 1;
    watch(1'b0);

    // No write reset since reset: counter is saturated
    rd_rst_i = 1; @(negedge clk); rd_rst_i = 0;
    chk("R6 read before any write reset", cls_o, 3);
    chk("R5 hazard before any write reset", hazard_o, 1);
    repeat (3) @(negedge clk);

    for (int d = 0; d <= DEPTH + 10; d++) lag_case(d);
    lag_case(DEPTH + 40);

    lag_case(5);
    wr_rst_i = 1; @(negedge clk); wr_rst_i = 0;
    repeat (4) @(negedge clk);
    chk("R2 write reset alone keeps code", cls_o, 1);

    watch(1'b1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule